// File: doc/BRIEF.md
# Bit-Parallel XOR Recurrence Random Generator

This block produces a fresh vector of `N` uniformly distributed pseudo-random bits on every enabled clock cycle. The state is exactly `N` flip-flops, and the output is the state itself. Each next-state bit is the XOR of at most `K` current state bits, chosen by a compile-time tap table, so every bit fits one small lookup table followed by one flip-flop. The map is a linear recurrence over GF(2). When the tap table is chosen for maximum period, the sequence visits all 2^N − 1 nonzero states before it repeats.

Consumers may slice the output into several narrower words of any width. Widths up to a few hundred bits are the intended range. A wider demand is met by placing several instances side by side, each with its own table and seed. The all-zero state would never leave itself, so the seed path and the reset value both replace a zero with the value 1.

Top module: `xor_recur_rng`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes `INIT_SEED`, or the value 1 (only bit 0 set) if `INIT_SEED` is zero. With the defaults, `rnd` reads 1 after reset.
- R2: When `load` is high and `seed` is nonzero, `rnd` equals `seed` one cycle later.
- R3: When `load` is high and `seed` is zero, `rnd` equals 1 (only bit 0 set) one cycle later.
- R4: `load` takes priority over `en`. With both high, the seed is taken and no advance happens.
- R5: With `rst`, `load` and `en` all low, `rnd` holds its value.
- R6: With `en` high and `load` low, each new bit i is the XOR of the current bits named in row i of `TAPS`. Entry j of row i is the `IW`-bit field at bit offset (i*K+j)*IW. Any entry whose value is N or greater is ignored.
- R7: `rnd` is never all zero at any cycle after reset.
- R8: With a maximum-period tap table and `en` held high, the output returns to its starting value after exactly 2^N − 1 advances, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset to the initial state |
| load | input | 1 | Load `seed` into the state this cycle |
| seed | input | N | Seed value; zero is replaced by 1 |
| en | input | 1 | Advance the recurrence this cycle |
| rnd | output | N | Random bit vector, equal to the state |

## Verification
The bench builds two instances. The first uses the defaults: N = 16, K = 2, with a two-input tap table of a primitive degree-16 polynomial. Its full cycle of 65535 states is short enough to walk completely. The second uses N = 8 and K = 3, with a scattered, permuted tap table whose rows include ignored entries. This reaches the unused-tap path and the 255-state period. Both are compared every cycle against bench models, under irregular enable patterns.

// File: rtl/xor_recur_rng.sv
module xor_recur_rng #(
  parameter int N = 16,
  parameter int K = 2,
  parameter int IW = $clog2(N + 1),
  parameter logic [N*K*IW-1:0] TAPS = {
    5'd31, 5'd0,  5'd31, 5'd15, 5'd0,  5'd14, 5'd0,  5'd13,
    5'd31, 5'd12, 5'd0,  5'd11, 5'd31, 5'd10, 5'd31, 5'd9,
    5'd31, 5'd8,  5'd31, 5'd7,  5'd31, 5'd6,  5'd31, 5'd5,
    5'd31, 5'd4,  5'd31, 5'd3,  5'd31, 5'd2,  5'd31, 5'd1
  },
  parameter logic [N-1:0] INIT_SEED = N'(1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] seed,
  input  logic         en,
  output logic [N-1:0] rnd
);

  localparam logic [N-1:0] ONE  = N'(1);
  localparam logic [N-1:0] BOOT = (INIT_SEED == '0) ? ONE : INIT_SEED;

  logic [N-1:0] state;
  logic [N-1:0] nxt;
  logic [N-1:0] seeded;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [K-1:0] picks;
    for (genvar j = 0; j < K; j++) begin : g_tap
      localparam int SEL = int'(TAPS[(i*K+j)*IW +: IW]);
      if (SEL < N) begin : g_use
        assign picks[j] = state[SEL];
      end else begin : g_skip
        assign picks[j] = 1'b0;
      end
    end
    assign nxt[i] = ^picks;
  end

  assign seeded = (seed == '0) ? ONE : seed;

  always_ff @(posedge clk) begin
    if (rst)       state <= BOOT;
    else if (load) state <= seeded;
    else if (en)   state <= nxt;
  end

  assign rnd = state;

  // R1
  reset_value_chk: assert property (@(posedge clk) rst |=> rnd == BOOT);

  // R2
  load_copies_seed_chk: assert property (@(posedge clk) disable iff (rst)
    load && seed != '0 |=> rnd == $past(seed));

  // R3
  zero_seed_chk: assert property (@(posedge clk) disable iff (rst)
    load && seed == '0 |=> rnd == ONE);

  // R4
  load_over_en_chk: assert property (@(posedge clk) disable iff (rst)
    load && en && seed != '0 |=> rnd == $past(seed));

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !load && !en |=> $stable(rnd));

  // R7
  never_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rnd != '0);

endmodule

// File: tb/xor_recur_rng_tb.sv
module xor_recur_rng_tb;
  localparam logic [95:0] TAPS8 = 96'hF02_FF1_FF0_F07_FF6_FF5_F04_FF3;

  logic clk = 1'b0;
  logic rst = 1'b1, load = 1'b0, en = 1'b0;
  logic [15:0] seed16 = '0;
  logic [7:0]  seed8 = '0;
  logic [15:0] rnd16;
  logic [7:0]  rnd8;
  logic [15:0] m16;
  logic [7:0]  m8;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  xor_recur_rng u_dut (
    .clk(clk), .rst(rst), .load(load), .seed(seed16), .en(en), .rnd(rnd16));

  xor_recur_rng #(.N(8), .K(3), .IW(4), .TAPS(TAPS8), .INIT_SEED(8'h00)) u_dut_small (
    .clk(clk), .rst(rst), .load(load), .seed(seed8), .en(en), .rnd(rnd8));

  function automatic logic [15:0] next16(logic [15:0] s);
    return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
  endfunction

  function automatic logic [7:0] next8(logic [7:0] s);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 3; j++) begin
        int idx = int'(TAPS8[(i*3+j)*4 +: 4]);
        if (idx < 8) r[i] = r[i] ^ s[idx];
      end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; load = 1'b0; en = 1'b1;
    step();
    rst = 1'b0; en = 1'b0;
    chk("R1 reset 16", 32'(rnd16), 32'h1);
    chk("R1 reset 8 zero init", 32'(rnd8), 32'h1);
    m16 = rnd16; m8 = rnd8;
  endtask

  task automatic t_load();
    load = 1'b1; en = 1'b0; seed16 = 16'hACE1; seed8 = 8'h5A;
    step();
    chk("R2 load 16", 32'(rnd16), 32'hACE1);
    chk("R2 load 8", 32'(rnd8), 32'h5A);
    en = 1'b1; seed16 = 16'h1234; seed8 = 8'hC3;
    step();
    chk("R4 load beats en 16", 32'(rnd16), 32'h1234);
    chk("R4 load beats en 8", 32'(rnd8), 32'hC3);
    load = 1'b0; en = 1'b0;
    m16 = rnd16; m8 = rnd8;
  endtask

  task automatic t_zero();
    load = 1'b1; seed16 = '0; seed8 = '0;
    step();
    load = 1'b0;
    chk("R3 zero seed 16", 32'(rnd16), 32'h1);
    chk("R3 zero seed 8", 32'(rnd8), 32'h1);
    m16 = rnd16; m8 = rnd8;
  endtask

  task automatic t_hold();
    load = 1'b1; seed16 = 16'h8001; seed8 = 8'h81;
    step();
    load = 1'b0; en = 1'b0;
    for (int c = 0; c < 5; c++) begin
      step();
      chk("R5 hold 16", 32'(rnd16), 32'h8001);
      chk("R5 hold 8", 32'(rnd8), 32'h81);
    end
    m16 = rnd16; m8 = rnd8;
  endtask

  task automatic t_stream();
    for (int c = 0; c < 300; c++) begin
      en = ((c % 3) != 2) || (c > 200);
      step();
      if (en) begin m16 = next16(m16); m8 = next8(m8); end
      chk("R6 recurrence 16", 32'(rnd16), 32'(m16));
      chk("R6 recurrence 8", 32'(rnd8), 32'(m8));
    end
    en = 1'b0;
  endtask

  task automatic t_period();
    int first16 = 0, first8 = 0, zeros = 0;
    load = 1'b1; seed16 = 16'h0001; seed8 = 8'h01; en = 1'b0;
    step();
    load = 1'b0; en = 1'b1;
    for (int n = 1; n <= 65535; n++) begin
      step();
      if (rnd16 == '0 || rnd8 == '0) zeros++;
      if (first8 == 0 && rnd8 == 8'h01) first8 = n;
      if (first16 == 0 && rnd16 == 16'h0001) first16 = n;
    end
    en = 1'b0;
    chk("R7 never zero", 32'(zeros), 32'd0);
    chk("R8 period 8", 32'(first8), 32'd255);
    chk("R8 period 16", 32'(first16), 32'd65535);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_load();
    t_zero();
    t_hold();
    t_stream();
    t_period();
    summary();
  end
endmodule